// File: doc/BRIEF.md
# Transmit Status Vector Generator

This block watches one outgoing frame at a time, across every attempt the transmit engine makes at putting it on the wire. While the bytes stream past, it decodes the destination address, the type/length field and the control opcode, tracks the per-attempt and cumulative byte counts, counts collisions, deferral bit times and backpressure, and runs a CRC-32 over the bytes of the current attempt. When the frame ends, the block freezes all of this into a 56-bit little-endian record. The frame ends in one of three ways: normal completion, an abort request, or a collision that ends the frame on its own.

The record is then written into the shared packet buffer as seven byte writes, at the seven addresses that follow the frame's end pointer. The block raises a request and waits for the buffer port to be granted. It then issues the seven writes back to back and pulses a done strobe. Monitoring inputs are not sampled between the finishing event and that strobe.

Top module: `txstat_gen`

## Requirements
- R1: A finishing event raises `buf_req_o`. On the cycle after `buf_gnt_i` is sampled high with the request, seven writes follow on consecutive cycles at addresses end pointer + 1 through end pointer + 7, modulo 2^AW. Write k (0..6) carries record bits 8k+7..8k. `done_o` is high for one cycle, the cycle right after the last write.
- R2: Record bits 15..0 hold the number of bytes sent in the last attempt. Bits 47..32 hold all bytes sent for the frame, collided attempts included.
- R3: Bits 19..16 hold the number of collisions the frame met, saturating at 15. A collision restarts the byte count and the header decode for the next attempt.
- R4: A collision that brings the count above the retry limit `cfg_retmax_i` sets bit 28 and ends the frame at once. A collision after more than `cfg_colwin_i` bytes of the attempt sets bit 29 and ends the frame at once. In both cases bits 15..0 report the bytes of the attempt that collided.
- R5: Bit 25 is set when all six destination bytes are 0xFF. Bit 24 is set when bit 0 of the first destination byte is 1 and the address is not broadcast. Both need at least 6 bytes sent.
- R6: The type/length field is bytes 12 (high) and 13 (low). Bit 51 marks 0x8100 and bit 48 marks 0x8808. Bit 49 marks 0x8808 with the opcode in bytes 14 (high) and 15 (low) equal to 0x0001. Bit 22 marks a field value above 1500.
- R7: Bit 21 is set only when `cfg_lenchk_i` is 1, the field is 1500 or less, and the frame size disagrees with it. The frame size agrees when it equals the field + 18, or when it is 64 and the field is 46 or less.
- R8: Each `defer_i` pulse counts one deferred bit time. Bit 27 is set when the count exceeds EXDEF_BITS. Bit 26 is set when at least one pulse came but the count did not exceed EXDEF_BITS.
- R9: Bit 30 is set when the last attempt carried more bytes than `cfg_maxlen_i`. Bit 50 is set when `bp_i` pulsed during the frame.
- R10: Bit 23 is set only for a normal end (`end_i`). An abort or a collision-ended frame leaves it 0. Bits 31 and 55..52 are always 0.
- R11: After reset, `buf_req_o`, `buf_we_o` and `done_o` are low.
- R12: Bit 20 is set on a normal end when the attempt's trailing four bytes, taken least significant byte first, are not the CRC-32 (reflected, initial all ones, final inversion) of the bytes before them. It is always 0 for an abort or a collision-ended frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fs_i | input | 1 | Frame start, clears all accumulators |
| byte_vld_i | input | 1 | A byte went onto the wire this cycle |
| byte_i | input | 8 | The byte sent |
| coll_i | input | 1 | Collision in the current attempt |
| defer_i | input | 1 | One bit time of deferral |
| bp_i | input | 1 | Backpressure was applied |
| end_i | input | 1 | Frame completed normally |
| abort_i | input | 1 | Frame cancelled or aborted |
| cfg_maxlen_i | input | 16 | Maximum frame length in bytes |
| cfg_retmax_i | input | 4 | Collision retry limit |
| cfg_colwin_i | input | 6 | Collision window in bytes |
| cfg_lenchk_i | input | 1 | Enable length field checking |
| cfg_end_ptr_i | input | AW | Buffer address of the frame's last byte |
| buf_req_o | output | 1 | Request for the buffer write port |
| buf_gnt_i | input | 1 | Buffer write port granted |
| buf_we_o | output | 1 | Buffer write enable |
| buf_addr_o | output | AW | Buffer write address |
| buf_data_o | output | 8 | Buffer write data |
| done_o | output | 1 | Record fully written |

## Verification
The bench builds the block with AW = 8 and EXDEF_BITS = 20. The narrow address makes an end pointer of 0xFC wrap the seven record writes across zero. The small deferral limit lets a few dozen `defer_i` pulses reach the excessive-deferral case and the limit just below it. Frames run against a retry limit of 2 and a collision window of 10 bytes, so frames ended by excessive collisions and by a late collision fit in a few dozen cycles. The grant is held back by a varying number of cycles to exercise the wait on the buffer port.

// File: rtl/txstat_pkg.sv
package txstat_pkg;

  localparam logic [15:0] TL_VLAN      = 16'h8100;
  localparam logic [15:0] TL_MACCTRL   = 16'h8808;
  localparam logic [15:0] OPC_PAUSE    = 16'h0001;
  localparam int unsigned LEN_LIMIT    = 1500;
  localparam int unsigned HDR_BYTES    = 14;
  localparam int unsigned FCS_BYTES    = 4;
  localparam int unsigned MIN_FRAME    = 64;
  localparam int unsigned MIN_PAYLOAD  = 46;
  localparam int unsigned DA_BYTES     = 6;
  localparam int unsigned TL_HI_IDX    = 12;
  localparam int unsigned TL_LO_IDX    = 13;
  localparam int unsigned OP_HI_IDX    = 14;
  localparam int unsigned OP_LO_IDX    = 15;
  localparam int unsigned VEC_BYTES    = 7;
  localparam int unsigned VEC_W        = 8 * VEC_BYTES;

  localparam logic [31:0] CRC_INIT     = 32'hFFFF_FFFF;
  localparam logic [31:0] CRC_POLY_R   = 32'hEDB8_8320;
  localparam logic [31:0] CRC_RESIDUE  = 32'hDEBB_20E3;

  // Record layout, most significant field first (bit 55 down to bit 0).
  typedef struct packed {
    logic [3:0]  zero_hi;     // 55:52
    logic        vlan;        // 51
    logic        backpress;   // 50
    logic        pause;       // 49
    logic        ctrl;        // 48
    logic [15:0] wire_bytes;  // 47:32
    logic        underrun;    // 31
    logic        giant;       // 30
    logic        late_coll;   // 29
    logic        exc_coll;    // 28
    logic        exc_defer;   // 27
    logic        deferred;    // 26
    logic        bcast;       // 25
    logic        mcast;       // 24
    logic        done;        // 23
    logic        len_range;   // 22
    logic        len_err;     // 21
    logic        crc_err;     // 20
    logic [3:0]  ncoll;       // 19:16
    logic [15:0] frame_bytes; // 15:0
  } txstat_vec_t;

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ CRC_POLY_R;
      else             r = r >> 1;
    end
    return r;
  endfunction

endpackage

// File: rtl/txstat_hdr.sv
module txstat_hdr
  import txstat_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          vld,
  input  logic [7:0]    dat,
  input  logic [CW-1:0] idx,
  output logic          bcast_o,
  output logic          mcast_o,
  output logic [15:0]   tl_o,
  output logic          tl_vld_o,
  output logic [15:0]   op_o,
  output logic          op_vld_o,
  output logic          crc_good_o
);

  logic        ones_q;
  logic        grp_q;
  logic [15:0] tl_q;
  logic [15:0] op_q;
  logic [31:0] crc_q;
  logic        da_seen;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      ones_q <= 1'b1;
      grp_q  <= 1'b0;
      tl_q   <= '0;
      op_q   <= '0;
      crc_q  <= CRC_INIT;
    end else if (vld) begin
      if (idx < CW'(DA_BYTES)) ones_q <= ones_q & (dat == 8'hFF);
      if (idx == '0)            grp_q  <= dat[0];
      if (idx == CW'(TL_HI_IDX)) tl_q[15:8] <= dat;
      if (idx == CW'(TL_LO_IDX)) tl_q[7:0]  <= dat;
      if (idx == CW'(OP_HI_IDX)) op_q[15:8] <= dat;
      if (idx == CW'(OP_LO_IDX)) op_q[7:0]  <= dat;
      crc_q <= crc_step(crc_q, dat);
    end
  end

  assign da_seen    = (idx >= CW'(DA_BYTES));
  assign bcast_o    = ones_q & da_seen;
  assign mcast_o    = grp_q & da_seen & ~bcast_o;
  assign tl_o       = tl_q;
  assign tl_vld_o   = (idx >= CW'(HDR_BYTES));
  assign op_o       = op_q;
  assign op_vld_o   = (idx >= CW'(OP_LO_IDX + 1));
  assign crc_good_o = (crc_q == CRC_RESIDUE);

endmodule

// File: rtl/txstat_cnt.sv
module txstat_cnt #(
  parameter int CW         = 16,
  parameter int EXDEF_BITS = 24287
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          act,
  input  logic          fs,
  input  logic          vld,
  input  logic          coll,
  input  logic          dfr,
  input  logic          bp,
  input  logic [3:0]    cfg_retmax,
  input  logic [5:0]    cfg_colwin,
  output logic [CW-1:0] att_o,
  output logic [CW-1:0] wire_o,
  output logic [3:0]    ncoll_o,
  output logic          late_o,
  output logic          excoll_o,
  output logic          deferred_o,
  output logic          exdef_o,
  output logic          bp_o
);

  localparam int DW      = $clog2(EXDEF_BITS + 2);
  localparam int DEF_SAT = EXDEF_BITS + 1;

  logic [CW-1:0] att_q, wire_q;
  logic [4:0]    nc_q, nc_nx;
  logic [DW-1:0] dcnt_q;
  logic          dfl_q, bp_q;

  assign nc_nx = nc_q + {4'b0000, coll};

  always_ff @(posedge clk) begin
    if (rst) begin
      att_q  <= '0;
      wire_q <= '0;
      nc_q   <= '0;
      dcnt_q <= '0;
      dfl_q  <= 1'b0;
      bp_q   <= 1'b0;
    end else if (act) begin
      if (fs) begin
        att_q  <= '0;
        wire_q <= '0;
        nc_q   <= '0;
        dcnt_q <= '0;
        dfl_q  <= 1'b0;
        bp_q   <= 1'b0;
      end else begin
        if (vld) begin
          att_q  <= att_q + 1'b1;
          wire_q <= wire_q + 1'b1;
        end
        if (coll) begin
          att_q <= '0;
          if (nc_q != 5'd31) nc_q <= nc_nx;
        end
        if (dfr) begin
          dfl_q <= 1'b1;
          if (dcnt_q < DW'(DEF_SAT)) dcnt_q <= dcnt_q + 1'b1;
        end
        if (bp) bp_q <= 1'b1;
      end
    end
  end

  assign att_o      = att_q;
  assign wire_o     = wire_q;
  assign ncoll_o    = (nc_nx > 5'd15) ? 4'hF : nc_nx[3:0];
  assign excoll_o   = act & coll & (nc_nx > {1'b0, cfg_retmax});
  assign late_o     = act & coll & (att_q > CW'(cfg_colwin));
  assign exdef_o    = (dcnt_q > DW'(EXDEF_BITS));
  assign deferred_o = dfl_q & ~exdef_o;
  assign bp_o       = bp_q;

endmodule

// File: rtl/txstat_wr.sv
module txstat_wr
  import txstat_pkg::*;
#(
  parameter int AW = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [VEC_W-1:0] vec,
  input  logic [AW-1:0]    base,
  input  logic             gnt,
  output logic             req_o,
  output logic             we_o,
  output logic [AW-1:0]    addr_o,
  output logic [7:0]       data_o,
  output logic             done_o,
  output logic             idle_o
);

  localparam int KW = $clog2(VEC_BYTES + 1);

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_SEND} wr_state_t;

  wr_state_t        st_q;
  logic [VEC_W-1:0] sh_q;
  logic [KW-1:0]    cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= S_IDLE;
      sh_q   <= '0;
      cnt_q  <= '0;
      req_o  <= 1'b0;
      we_o   <= 1'b0;
      addr_o <= '0;
      data_o <= '0;
      done_o <= 1'b0;
    end else begin
      we_o   <= 1'b0;
      done_o <= 1'b0;
      case (st_q)
        S_IDLE: begin
          if (start) begin
            sh_q   <= vec;
            addr_o <= base + AW'(1);
            req_o  <= 1'b1;
            st_q   <= S_REQ;
          end
        end
        S_REQ: begin
          if (gnt) begin
            req_o  <= 1'b0;
            we_o   <= 1'b1;
            data_o <= sh_q[7:0];
            sh_q   <= {8'h00, sh_q[VEC_W-1:8]};
            cnt_q  <= KW'(1);
            st_q   <= S_SEND;
          end
        end
        default: begin
          if (cnt_q < KW'(VEC_BYTES)) begin
            we_o   <= 1'b1;
            addr_o <= addr_o + AW'(1);
            data_o <= sh_q[7:0];
            sh_q   <= {8'h00, sh_q[VEC_W-1:8]};
            cnt_q  <= cnt_q + 1'b1;
          end else begin
            done_o <= 1'b1;
            st_q   <= S_IDLE;
          end
        end
      endcase
    end
  end

  assign idle_o = (st_q == S_IDLE);

endmodule

// File: rtl/txstat_gen.sv
module txstat_gen
  import txstat_pkg::*;
#(
  parameter int AW         = 13,
  parameter int CW         = 16,
  parameter int EXDEF_BITS = 24287
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fs_i,
  input  logic          byte_vld_i,
  input  logic [7:0]    byte_i,
  input  logic          coll_i,
  input  logic          defer_i,
  input  logic          bp_i,
  input  logic          end_i,
  input  logic          abort_i,
  input  logic [15:0]   cfg_maxlen_i,
  input  logic [3:0]    cfg_retmax_i,
  input  logic [5:0]    cfg_colwin_i,
  input  logic          cfg_lenchk_i,
  input  logic [AW-1:0] cfg_end_ptr_i,
  output logic          buf_req_o,
  input  logic          buf_gnt_i,
  output logic          buf_we_o,
  output logic [AW-1:0] buf_addr_o,
  output logic [7:0]    buf_data_o,
  output logic          done_o
);

  logic          act;
  logic          dec_clr;
  logic          bcast, mcast, tl_vld, op_vld, crc_good;
  logic [15:0]   tl, op;
  logic [CW-1:0] att, wire_n;
  logic [3:0]    ncoll;
  logic          late, excoll, deferred, exdef, bp_seen;
  logic          fatal, finish_ok, trigger;
  logic          is_len, size_ok, ctrl;
  txstat_vec_t   vec;

  assign dec_clr = act & (fs_i | coll_i);

  txstat_hdr #(.CW(CW)) u_hdr (
    .clk(clk), .rst(rst), .clr(dec_clr), .vld(act & byte_vld_i), .dat(byte_i), .idx(att),
    .bcast_o(bcast), .mcast_o(mcast), .tl_o(tl), .tl_vld_o(tl_vld),
    .op_o(op), .op_vld_o(op_vld), .crc_good_o(crc_good)
  );

  txstat_cnt #(.CW(CW), .EXDEF_BITS(EXDEF_BITS)) u_cnt (
    .clk(clk), .rst(rst), .act(act), .fs(fs_i), .vld(byte_vld_i), .coll(coll_i),
    .dfr(defer_i), .bp(bp_i), .cfg_retmax(cfg_retmax_i), .cfg_colwin(cfg_colwin_i),
    .att_o(att), .wire_o(wire_n), .ncoll_o(ncoll), .late_o(late), .excoll_o(excoll),
    .deferred_o(deferred), .exdef_o(exdef), .bp_o(bp_seen)
  );

  assign fatal     = excoll | late;
  assign finish_ok = act & end_i & ~fatal;
  assign trigger   = act & (end_i | abort_i | fatal);

  assign is_len  = (tl <= 16'(LEN_LIMIT));
  assign size_ok = (32'(att) == 32'(tl) + 32'(HDR_BYTES + FCS_BYTES)) ||
                   ((32'(att) == 32'(MIN_FRAME)) && (tl <= 16'(MIN_PAYLOAD)));
  assign ctrl    = tl_vld & (tl == TL_MACCTRL);

  always_comb begin
    vec             = '0;
    vec.frame_bytes = 16'(att);
    vec.wire_bytes  = 16'(wire_n);
    vec.ncoll       = ncoll;
    vec.exc_coll    = excoll;
    vec.late_coll   = late;
    vec.bcast       = bcast;
    vec.mcast       = mcast;
    vec.vlan        = tl_vld & (tl == TL_VLAN);
    vec.ctrl        = ctrl;
    vec.pause       = ctrl & op_vld & (op == OPC_PAUSE);
    vec.len_range   = tl_vld & ~is_len;
    vec.len_err     = cfg_lenchk_i & tl_vld & is_len & ~size_ok;
    vec.deferred    = deferred;
    vec.exc_defer   = exdef;
    vec.giant       = (32'(att) > 32'(cfg_maxlen_i));
    vec.backpress   = bp_seen;
    vec.done        = finish_ok;
    vec.crc_err     = finish_ok & ~crc_good;
  end

  txstat_wr #(.AW(AW)) u_wr (
    .clk(clk), .rst(rst), .start(trigger), .vec(vec), .base(cfg_end_ptr_i),
    .gnt(buf_gnt_i), .req_o(buf_req_o), .we_o(buf_we_o), .addr_o(buf_addr_o),
    .data_o(buf_data_o), .done_o(done_o), .idle_o(act)
  );

endmodule

// File: rtl/txstat_gen_chk.sv
module txstat_gen_chk #(
  parameter int AW = 13
) (
  input logic          clk,
  input logic          rst,
  input logic          req,
  input logic          gnt,
  input logic          we,
  input logic [AW-1:0] addr,
  input logic          done
);

  // R1: a grant seen with the request starts the writes on the next cycle
  a_r1_grant_starts_write: assert property (@(posedge clk) disable iff (rst)
    (req && gnt) |=> we);

  // R1: back-to-back writes step the address by one
  a_r1_addr_increments: assert property (@(posedge clk) disable iff (rst)
    (we && $past(we)) |-> (addr == $past(addr) + AW'(1)));

  // R1: done directly follows the last write
  a_r1_done_after_write: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(we) && !we));

  // R1: request is dropped before any write
  a_r1_no_req_during_write: assert property (@(posedge clk) disable iff (rst)
    !(req && we));

  // R1: done lasts a single cycle
  a_r1_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

endmodule

bind txstat_gen txstat_gen_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .req(buf_req_o), .gnt(buf_gnt_i), .we(buf_we_o),
  .addr(buf_addr_o), .done(done_o)
);

// File: tb/txstat_gen_test.sv
module txstat_gen_test;

  localparam int AW    = 8;
  localparam int EXDEF = 20;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          fs = 0, bv = 0, coll = 0, dfr = 0, bp = 0, fin = 0, abrt = 0;
  logic [7:0]    bd = '0;
  logic [15:0]   maxlen = 16'd1518;
  logic [3:0]    retmax = 4'd15;
  logic [5:0]    colwin = 6'd63;
  logic          lenchk = 1'b1;
  logic [AW-1:0] endptr = '0;
  logic          gnt = 1'b0;
  logic          req, we, done;
  logic [AW-1:0] addr;
  logic [7:0]    wdat;

  always #5 clk = ~clk;

  txstat_gen #(.AW(AW), .CW(16), .EXDEF_BITS(EXDEF)) uut (
    .clk(clk), .rst(rst), .fs_i(fs), .byte_vld_i(bv), .byte_i(bd), .coll_i(coll),
    .defer_i(dfr), .bp_i(bp), .end_i(fin), .abort_i(abrt), .cfg_maxlen_i(maxlen),
    .cfg_retmax_i(retmax), .cfg_colwin_i(colwin), .cfg_lenchk_i(lenchk),
    .cfg_end_ptr_i(endptr), .buf_req_o(req), .buf_gnt_i(gnt), .buf_we_o(we),
    .buf_addr_o(addr), .buf_data_o(wdat), .done_o(done)
  );

  typedef struct { logic [AW-1:0] base; logic [55:0] vec; } exp_t;
  exp_t q[$];

  int n_chk = 0, n_fail = 0, n_done = 0, gnt_delay = 0, gwait = 0;
  logic [7:0] frm [0:127];

  task automatic check(input bit ok, input string tag, input logic [63:0] a, input logic [63:0] e);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, a, e);
    end
  endtask

  function automatic logic [31:0] crc32(input int len);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int i = 0; i < len; i++) begin
      c = c ^ {24'h0, frm[i]};
      for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
    end
    return ~c;
  endfunction

  function automatic bit fcs_ok(input int n);
    if (n < 4) return 1'b0;
    return {frm[n-1], frm[n-2], frm[n-3], frm[n-4]} == crc32(n - 4);
  endfunction

  task automatic build(input logic [47:0] da, input logic [15:0] tl, input logic [15:0] op,
                       input int n, input bit good);
    for (int i = 0; i < 6; i++) frm[i] = da[47-8*i -: 8];
    frm[6] = 8'h02; frm[7] = 8'h00; frm[8] = 8'h00; frm[9] = 8'h00; frm[10] = 8'h00; frm[11] = 8'h01;
    frm[12] = tl[15:8]; frm[13] = tl[7:0]; frm[14] = op[15:8]; frm[15] = op[7:0];
    for (int i = 16; i < n - 4; i++) frm[i] = 8'(i * 3);
    {frm[n-1], frm[n-2], frm[n-3], frm[n-4]} = crc32(n - 4);
    if (!good) frm[n-1] = frm[n-1] ^ 8'h01;
  endtask

  function automatic logic [55:0] expect_vec(input int n, input int pre, input int clen,
                                             input int dn, input bit bpf, input int kind);
    logic [55:0] v = '0;
    int nc;
    bit bc;
    logic [15:0] tl, op;
    v[15:0]  = 16'(n);
    v[47:32] = 16'(pre * clen + n);
    nc = pre + ((kind == 2) ? 1 : 0);
    v[19:16] = (nc > 15) ? 4'hF : 4'(nc);
    if (kind == 2) begin
      v[28] = (nc > int'(retmax));
      v[29] = (n > int'(colwin));
    end
    if (n >= 6) begin
      bc = 1'b1;
      for (int i = 0; i < 6; i++) if (frm[i] != 8'hFF) bc = 1'b0;
      v[25] = bc;
      v[24] = frm[0][0] && !bc;
    end
    if (n >= 14) begin
      tl = {frm[12], frm[13]};
      v[51] = (tl == 16'h8100);
      v[48] = (tl == 16'h8808);
      v[22] = (tl > 16'd1500);
      if (lenchk && tl <= 16'd1500 && !(n == int'(tl) + 18 || (n == 64 && tl <= 16'd46))) v[21] = 1'b1;
      op = {frm[14], frm[15]};
      if (n >= 16 && tl == 16'h8808 && op == 16'h0001) v[49] = 1'b1;
    end
    v[50] = bpf;
    v[27] = (dn > EXDEF);
    v[26] = (dn > 0) && (dn <= EXDEF);
    v[30] = (n > int'(maxlen));
    v[23] = (kind == 0);
    if (kind == 0) v[20] = !fcs_ok(n);
    return v;
  endfunction

  // Driver: sends one frame, pushes the expected record, waits for its done
  task automatic send(input int n, input int pre, input int clen, input int dn,
                      input bit bpf, input int kind, input int gdel);
    exp_t e;
    int start_done;
    e.base = endptr;
    e.vec  = expect_vec(n, pre, clen, dn, bpf, kind);
    q.push_back(e);
    gnt_delay  = gdel;
    start_done = n_done;
    @(negedge clk) fs = 1;
    @(negedge clk) fs = 0;
    for (int i = 0; i < dn; i++) begin
      dfr = 1; @(negedge clk);
    end
    dfr = 0;
    if (bpf) begin bp = 1; @(negedge clk); bp = 0; end
    for (int a = 0; a < pre; a++) begin
      for (int i = 0; i < clen; i++) begin bv = 1; bd = frm[i]; @(negedge clk); end
      bv = 0; coll = 1; @(negedge clk); coll = 0;
    end
    for (int i = 0; i < n; i++) begin bv = 1; bd = frm[i]; @(negedge clk); end
    bv = 0;
    if (kind == 0) fin = 1; else if (kind == 1) abrt = 1; else coll = 1;
    @(negedge clk);
    fin = 0; abrt = 0; coll = 0;
    while (n_done == start_done) @(negedge clk);
  endtask

  // Grant generator
  initial begin
    forever begin
      @(negedge clk);
      if (gnt) gnt = 1'b0;
      else if (req) begin
        if (gwait > 0) gwait--;
        else begin gnt = 1'b1; gwait = gnt_delay; end
      end else gwait = gnt_delay;
    end
  end

  // Monitor / scoreboard
  initial begin
    int k;
    logic [55:0] got;
    exp_t e;
    k = 0; got = '0;
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (we) begin
          if (q.size() == 0) check(1'b0, "R1 write with nothing expected", 0, 0);
          else check(addr == q[0].base + AW'(k + 1), "R1 address", 64'(addr), 64'(q[0].base + AW'(k + 1)));
          if (k < 7) got[8*k +: 8] = wdat;
          k++;
        end
        if (done) begin
          check(k == 7, "R1 write count before done", 64'(k), 7);
          if (q.size() > 0) begin
            e = q.pop_front();
            check(got[15:0]  == e.vec[15:0],  "R2 frame bytes", 64'(got[15:0]), 64'(e.vec[15:0]));
            check(got[47:32] == e.vec[47:32], "R2 wire bytes",  64'(got[47:32]), 64'(e.vec[47:32]));
            check(got[19:16] == e.vec[19:16], "R3 collisions",  64'(got[19:16]), 64'(e.vec[19:16]));
            check(got[28] == e.vec[28], "R4 excessive collisions", 64'(got[28]), 64'(e.vec[28]));
            check(got[29] == e.vec[29], "R4 late collision", 64'(got[29]), 64'(e.vec[29]));
            check(got[25] == e.vec[25], "R5 broadcast", 64'(got[25]), 64'(e.vec[25]));
            check(got[24] == e.vec[24], "R5 multicast", 64'(got[24]), 64'(e.vec[24]));
            check(got[51] == e.vec[51], "R6 vlan", 64'(got[51]), 64'(e.vec[51]));
            check(got[48] == e.vec[48], "R6 control", 64'(got[48]), 64'(e.vec[48]));
            check(got[49] == e.vec[49], "R6 pause", 64'(got[49]), 64'(e.vec[49]));
            check(got[22] == e.vec[22], "R6 length range", 64'(got[22]), 64'(e.vec[22]));
            check(got[21] == e.vec[21], "R7 length check", 64'(got[21]), 64'(e.vec[21]));
            check(got[27] == e.vec[27], "R8 excessive defer", 64'(got[27]), 64'(e.vec[27]));
            check(got[26] == e.vec[26], "R8 deferred", 64'(got[26]), 64'(e.vec[26]));
            check(got[30] == e.vec[30], "R9 giant", 64'(got[30]), 64'(e.vec[30]));
            check(got[50] == e.vec[50], "R9 backpressure", 64'(got[50]), 64'(e.vec[50]));
            check(got[23] == e.vec[23], "R10 done bit", 64'(got[23]), 64'(e.vec[23]));
            check(got[31] == 1'b0 && got[55:52] == 4'h0, "R10 zero bits", 64'({got[55:52], got[31]}), 0);
            check(got[20] == e.vec[20], "R12 crc error", 64'(got[20]), 64'(e.vec[20]));
          end else check(1'b0, "R1 done with nothing expected", 0, 0);
          k = 0; got = '0;
          n_done++;
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(!req && !we && !done, "R11 reset state", 64'({req, we, done}), 0);

    // Broadcast, type field, good FCS
    endptr = 8'h20;
    build(48'hFFFF_FFFF_FFFF, 16'h0800, 16'h0000, 64, 1);
    send(64, 0, 0, 0, 0, 0, 0);

    // Multicast, padded length, two collisions, short deferral
    endptr = 8'h50;
    build(48'h0100_5E00_0001, 16'd46, 16'h0000, 64, 1);
    send(64, 2, 10, 5, 0, 0, 3);

    // Giant, bad FCS, length mismatch, backpressure
    endptr = 8'h40; maxlen = 16'd64;
    build(48'h0200_0000_0099, 16'd30, 16'h0000, 70, 0);
    send(70, 0, 0, 0, 1, 0, 1);
    maxlen = 16'd1518;

    // Pause control frame, excessive deferral, address wrap
    endptr = 8'hFC;
    build(48'h0180_C200_0001, 16'h8808, 16'h0001, 64, 1);
    send(64, 0, 0, 25, 0, 0, 2);

    // Deferral right at the limit
    endptr = 8'h10;
    build(48'h0200_0000_0001, 16'h0800, 16'h0000, 64, 1);
    send(64, 0, 0, EXDEF, 0, 0, 0);

    // VLAN tagged, aborted midway
    endptr = 8'h60;
    build(48'h0200_0000_0002, 16'h8100, 16'h0000, 64, 1);
    send(20, 0, 0, 0, 0, 1, 0);

    // Excessive collisions
    endptr = 8'h70; retmax = 4'd2;
    build(48'h0200_0000_0003, 16'h0600, 16'h0000, 64, 1);
    send(8, 2, 8, 0, 0, 2, 0);
    retmax = 4'd15;

    // Late collision
    endptr = 8'h80; colwin = 6'd10;
    build(48'h0200_0000_0004, 16'd16, 16'h0000, 64, 1);
    send(15, 0, 0, 0, 0, 2, 0);
    colwin = 6'd63;

    // Exact length match
    endptr = 8'h90;
    build(48'h0200_0000_0005, 16'd30, 16'h0000, 48, 1);
    send(48, 0, 0, 0, 0, 0, 0);

    // Length checking disabled with a mismatch
    endptr = 8'hA0; lenchk = 1'b0;
    build(48'h0200_0000_0006, 16'd30, 16'h0000, 60, 1);
    send(60, 0, 0, 0, 0, 0, 0);

    repeat (4) @(negedge clk);
    check(q.size() == 0, "R1 all records written", 64'(q.size()), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule